// File: doc/BRIEF.md
# Double-Buffer DMA Address Selector

This block holds the addressing state of one DMA stream and supplies the source and destination addresses that the transfer engine uses. It stores a peripheral address, two memory buffer addresses and a control word. The control word holds the enable, ping-pong mode, circular mode, transfer direction and the current-target bit. In ping-pong mode the memory side alternates between the two buffers. The current-target bit flips each time an external item counter reports that a buffer is complete, and the block raises a reload strobe so that the counter restarts in the same cycle.

The block also guards configuration. While the stream runs, the peripheral address and the control fields are frozen. A memory address is also frozen, except in ping-pong mode, where the buffer that is not in use may be refilled with a new address. If software tries to enable a combination that cannot run, the enable is refused and an error flag is raised.

All writes go through one register port: `wr_sel_i` 0 selects the control word, 1 the peripheral address, 2 memory buffer 0 and 3 memory buffer 1. The control word bits are: bit 0 enable, bit 1 ping-pong mode, bit 2 circular, bits 4:3 direction, bit 5 current target.

Top module: `dbuf_addr_sel`

## Requirements
- R1: After reset the stream is disabled, every address register, the current target, the direction and the error flag are zero, and the reload strobe is low.
- R2: With direction code 00 (peripheral to memory), the source is the peripheral address and the destination is the active memory buffer. The active buffer is buffer 1 when ping-pong mode and the current target are both 1, and buffer 0 otherwise.
- R3: With direction code 01 (memory to peripheral), the source is the active memory buffer and the destination is the peripheral address.
- R4: With direction code 10 (memory to memory), the source is the peripheral address register and the destination is buffer 0. With code 11 (reserved), both addresses are zero.
- R5: While ping-pong mode is set, the circular output reads 1 whatever the circular bit holds.
- R6: A control write with bit 0 set while disabled leaves the stream disabled and sets the error flag when the direction is 11, or when ping-pong mode is set with direction 10. Any other control write while disabled clears the error flag.
- R7: A transfer-complete strobe while enabled in ping-pong mode inverts the current target in the next cycle. In all other cases the current target holds while enabled, and it is loaded from control bit 5 by a write while disabled.
- R8: The reload strobe is high in the same cycle as a transfer-complete strobe when the stream is enabled and circular (directly or through ping-pong mode); the stream then stays enabled. A strobe in a non-circular stream leaves reload low and disables the stream in the next cycle.
- R9: While enabled without ping-pong mode, writes to the peripheral address and to both memory buffers are ignored.
- R10: While enabled in ping-pong mode, writes to the peripheral address and to the buffer that the current target selects are ignored, and a write to the other buffer is accepted.
- R11: While enabled, a control write changes only the enable: bit 0 clear disables the stream, and every other field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 peripheral, 2 buffer 0, 3 buffer 1 |
| wr_data_i | input | AW | Write data |
| tc_i | input | 1 | Buffer transfer complete, from the item counter |
| en_o | output | 1 | Stream enabled |
| dbuf_o | output | 1 | Ping-pong mode |
| circ_o | output | 1 | Effective circular mode |
| dir_o | output | 2 | Direction code |
| ct_o | output | 1 | Current target |
| cfg_err_o | output | 1 | Refused enable flag |
| reload_o | output | 1 | Item counter reload, same cycle as tc_i |
| src_addr_o | output | AW | Active source address |
| dst_addr_o | output | AW | Active destination address |

## Verification
The assertions assume that `tc_i` pulses only while the stream is enabled, for one cycle at a time. They also assume that a control write does not fall in the same cycle as a transfer-complete strobe. The lock properties assume that the item counter does not report completion on the cycle being checked. The bench drives writes and strobes from separate tasks, one per cycle with an idle cycle between, so these conditions hold. It sweeps every combination of direction, ping-pong, circular and initial target.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [1:0] {
    DIR_P2M  = 2'b00,
    DIR_M2P  = 2'b01,
    DIR_M2M  = 2'b10,
    DIR_RSVD = 2'b11
  } dir_e;

  localparam int NBUF   = 2;
  localparam int SEL_W  = 2;
  localparam int CTRL_W = 6;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_PADDR = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MEM0  = 2'd2;

  localparam int CB_EN   = 0;
  localparam int CB_DBUF = 1;
  localparam int CB_CIRC = 2;
  localparam int CB_DIR  = 3;
  localparam int CB_CT   = 5;

  function automatic logic cfg_legal(dir_e d, logic dbuf);
    return (d != DIR_RSVD) && !(dbuf && d == DIR_M2M);
  endfunction
endpackage

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
  import dbuf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              tc_i,
  output logic              en_o,
  output logic              dbuf_o,
  output logic              circ_o,
  output dir_e              dir_o,
  output logic              ct_o,
  output logic              cfg_err_o,
  output logic              reload_o
);
  logic en_q, dbuf_q, circ_q, ct_q, err_q;
  dir_e dir_q;
  dir_e wr_dir;
  logic wr_legal, circ_eff;

  assign wr_dir   = dir_e'(ctrl_data_i[CB_DIR+1:CB_DIR]);
  assign wr_legal = cfg_legal(wr_dir, ctrl_data_i[CB_DBUF]);
  assign circ_eff = circ_q | dbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      dbuf_q <= 1'b0;
      circ_q <= 1'b0;
      dir_q  <= DIR_P2M;
      ct_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (en_q) begin
      if (tc_i) begin
        if (dbuf_q)    ct_q <= ~ct_q;
        if (!circ_eff) en_q <= 1'b0;
      end
      // fields frozen while running; only a disable is honoured
      if (ctrl_wr_i && !ctrl_data_i[CB_EN]) en_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      dbuf_q <= ctrl_data_i[CB_DBUF];
      circ_q <= ctrl_data_i[CB_CIRC];
      dir_q  <= wr_dir;
      ct_q   <= ctrl_data_i[CB_CT];
      if (ctrl_data_i[CB_EN] && !wr_legal) begin
        en_q  <= 1'b0;
        err_q <= 1'b1;
      end else begin
        en_q  <= ctrl_data_i[CB_EN];
        err_q <= 1'b0;
      end
    end
  end

  assign en_o      = en_q;
  assign dbuf_o    = dbuf_q;
  assign circ_o    = circ_eff;
  assign dir_o     = dir_q;
  assign ct_o      = ct_q;
  assign cfg_err_o = err_q;
  assign reload_o  = en_q & tc_i & circ_eff;
endmodule

// File: rtl/dbuf_addr_regs.sv
module dbuf_addr_regs
  import dbuf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SEL_W-1:0]         wr_sel_i,
  input  logic [AW-1:0]            wr_data_i,
  input  logic                     en_i,
  input  logic                     dbuf_i,
  input  logic                     ct_i,
  output logic [AW-1:0]            paddr_o,
  output logic [NBUF-1:0][AW-1:0]  mem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       paddr_o <= '0;
    else if (wr_en_i && wr_sel_i == SEL_PADDR && !en_i) paddr_o <= wr_data_i;
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_mem
    localparam logic [SEL_W-1:0] MY_SEL = SEL_MEM0 + SEL_W'(g);
    logic open_w;
    // idle stream, or the buffer the engine is not using
    assign open_w = !en_i || (dbuf_i && (ct_i != g[0]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_o[g] <= '0;
      else if (wr_en_i && wr_sel_i == MY_SEL && open_w) mem_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/dbuf_addr_mux.sv
module dbuf_addr_mux
  import dbuf_pkg::*;
#(
  parameter int AW = 32
) (
  input  dir_e                     dir_i,
  input  logic                     dbuf_i,
  input  logic                     ct_i,
  input  logic [AW-1:0]            paddr_i,
  input  logic [NBUF-1:0][AW-1:0]  mem_i,
  output logic [AW-1:0]            src_o,
  output logic [AW-1:0]            dst_o
);
  logic [AW-1:0] mem_act;
  assign mem_act = mem_i[dbuf_i & ct_i];

  always_comb begin
    unique case (dir_i)
      DIR_P2M: begin src_o = paddr_i; dst_o = mem_act;  end
      DIR_M2P: begin src_o = mem_act; dst_o = paddr_i;  end
      DIR_M2M: begin src_o = paddr_i; dst_o = mem_i[0]; end
      default: begin src_o = '0;      dst_o = '0;       end
    endcase
  end
endmodule

// File: rtl/dbuf_addr_sel.sv
module dbuf_addr_sel
  import dbuf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             tc_i,
  output logic             en_o,
  output logic             dbuf_o,
  output logic             circ_o,
  output logic [1:0]       dir_o,
  output logic             ct_o,
  output logic             cfg_err_o,
  output logic             reload_o,
  output logic [AW-1:0]    src_addr_o,
  output logic [AW-1:0]    dst_addr_o
);
  dir_e                    dir_w;
  logic [AW-1:0]           paddr_w;
  logic [NBUF-1:0][AW-1:0] mem_w;

  dbuf_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (wr_en_i && wr_sel_i == SEL_CTRL),
    .ctrl_data_i (wr_data_i[CTRL_W-1:0]),
    .tc_i        (tc_i),
    .en_o        (en_o),
    .dbuf_o      (dbuf_o),
    .circ_o      (circ_o),
    .dir_o       (dir_w),
    .ct_o        (ct_o),
    .cfg_err_o   (cfg_err_o),
    .reload_o    (reload_o)
  );

  dbuf_addr_regs #(.AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .en_i      (en_o),
    .dbuf_i    (dbuf_o),
    .ct_i      (ct_o),
    .paddr_o   (paddr_w),
    .mem_o     (mem_w)
  );

  dbuf_addr_mux #(.AW(AW)) u_mux (
    .dir_i   (dir_w),
    .dbuf_i  (dbuf_o),
    .ct_i    (ct_o),
    .paddr_i (paddr_w),
    .mem_i   (mem_w),
    .src_o   (src_addr_o),
    .dst_o   (dst_addr_o)
  );

  assign dir_o = dir_w;
endmodule

// File: rtl/dbuf_addr_sel_chk.sv
module dbuf_addr_sel_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic [AW-1:0] wr_data_i,
  input logic          tc_i,
  input logic          en_o,
  input logic          dbuf_o,
  input logic          circ_o,
  input logic [1:0]    dir_o,
  input logic          ct_o,
  input logic          cfg_err_o,
  input logic          reload_o,
  input logic [AW-1:0] src_addr_o,
  input logic [AW-1:0] dst_addr_o
);
  logic ctrl_wr, bad_en;
  assign ctrl_wr = wr_en_i && wr_sel_i == 2'd0;
  assign bad_en  = ctrl_wr && wr_data_i[0] &&
                   (wr_data_i[4:3] == 2'b11 || (wr_data_i[1] && wr_data_i[4:3] == 2'b10));

  AST_DBUF_FORCES_CIRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbuf_o |-> circ_o); // R5
  AST_EN_ONLY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (dir_o != 2'b11 && !(dbuf_o && dir_o == 2'b10))); // R6
  AST_BAD_EN_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && bad_en) |=> (!en_o && cfg_err_o)); // R6
  AST_CT_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && dbuf_o && tc_i) |=> (ct_o != $past(ct_o))); // R7
  AST_CT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !tc_i) |=> $stable(ct_o)); // R7
  AST_CIRC_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && tc_i && circ_o && !ctrl_wr) |=> en_o); // R8
  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && tc_i && !circ_o) |=> (!en_o && !$past(reload_o))); // R8
  AST_PADDR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && dir_o == 2'b00) |=> $stable(src_addr_o)); // R9
  AST_ACTIVE_BUF_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && dbuf_o && dir_o == 2'b00 && !tc_i) |=> $stable(dst_addr_o)); // R10
endmodule

bind dbuf_addr_sel dbuf_addr_sel_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .tc_i       (tc_i),
  .en_o       (en_o),
  .dbuf_o     (dbuf_o),
  .circ_o     (circ_o),
  .dir_o      (dir_o),
  .ct_o       (ct_o),
  .cfg_err_o  (cfg_err_o),
  .reload_o   (reload_o),
  .src_addr_o (src_addr_o),
  .dst_addr_o (dst_addr_o)
);

// File: tb/dbuf_addr_sel_tb.sv
module dbuf_addr_sel_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          tc = 1'b0;
  logic          en, dbuf, circ, ct, cfg_err, reload;
  logic [1:0]    dir;
  logic [AW-1:0] src, dst;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dbuf_addr_sel #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tc_i(tc), .en_o(en), .dbuf_o(dbuf), .circ_o(circ),
    .dir_o(dir), .ct_o(ct), .cfg_err_o(cfg_err), .reload_o(reload),
    .src_addr_o(src), .dst_addr_o(dst)
  );

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [AW-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tc(logic exp_reload);
    @(negedge clk);
    tc = 1'b1;
    #2 check("R8 reload", AW'(reload), AW'(exp_reload));
    @(negedge clk);
    tc = 1'b0;
  endtask

  function automatic logic [AW-1:0] exp_addr(logic want_src, int d, logic db, logic c,
                                             logic [AW-1:0] pa, logic [AW-1:0] m0,
                                             logic [AW-1:0] m1);
    logic [AW-1:0] m;
    m = (db && c) ? m1 : m0;
    case (d)
      0: return want_src ? pa : m;
      1: return want_src ? m : pa;
      2: return want_src ? pa : m0;
      default: return '0;
    endcase
  endfunction

  function automatic string dir_req(int d);
    case (d)
      0: return "R2";
      1: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_addr(string req, int d, logic db, logic c,
                            logic [AW-1:0] pa, logic [AW-1:0] m0, logic [AW-1:0] m1);
    check({req, " src"}, src, exp_addr(1'b1, d, db, c, pa, m0, m1));
    check({req, " dst"}, dst, exp_addr(1'b0, d, db, c, pa, m0, m1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 en", AW'(en), 0);
    check("R1 ct", AW'(ct), 0);
    check("R1 err", AW'(cfg_err), 0);
    check("R1 dir", AW'(dir), 0);
    check("R1 src", src, 0);
    check("R1 dst", dst, 0);
    check("R1 reload", AW'(reload), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 32; i++) begin
      int d;
      logic db, ci, c, legal, c_now, en_exp;
      logic [AW-1:0] pa, m0, m1, cw, bad_cw;
      d  = i & 3;
      db = 1'((i >> 2) & 1);
      ci = 1'((i >> 3) & 1);
      c  = 1'((i >> 4) & 1);

      wr(2'd0, '0);
      check("R6 err cleared", AW'(cfg_err), 0);
      check("R11 disabled", AW'(en), 0);

      pa = 32'h1000_0000 + AW'(i * 16);
      m0 = 32'h2000_0000 + AW'(i * 16);
      m1 = 32'h3000_0000 + AW'(i * 16);
      wr(2'd1, pa); wr(2'd2, m0); wr(2'd3, m1);

      cw = AW'((int'(c) << 5) | (d << 3) | (int'(ci) << 2) | (int'(db) << 1) | 1);
      wr(2'd0, cw);
      legal = (d != 3) && !(db && d == 2);
      check("R6 en", AW'(en), AW'(legal));
      check("R6 err", AW'(cfg_err), AW'(!legal));
      check("R5 circ", AW'(circ), AW'(ci | db));
      check("R7 ct load", AW'(ct), AW'(c));
      check_addr(dir_req(d), d, db, c, pa, m0, m1);

      if (legal) begin
        wr(2'd2 + 2'(c), 32'hDEAD_0000 | AW'(i));
        wr(2'd2 + 2'(!c), 32'hBEEF_0000 | AW'(i));
        wr(2'd1, 32'hCAFE_0000 | AW'(i));
        if (db) begin
          if (c) m0 = 32'hBEEF_0000 | AW'(i);
          else   m1 = 32'hBEEF_0000 | AW'(i);
        end
        check_addr(db ? "R10 lock" : "R9 lock", d, db, c, pa, m0, m1);

        pulse_tc(ci | db);
        en_exp = ci | db;
        c_now  = c ^ db;
        check("R8 en after tc", AW'(en), AW'(en_exp));
        check("R7 ct after tc", AW'(ct), AW'(c_now));
        check_addr(db ? "R10 other buf" : "R9 after tc", d, db, c_now, pa, m0, m1);

        if (en_exp) begin
          bad_cw = AW'((int'(!c_now) << 5) | ((d ^ 3) << 3) | (int'(!ci) << 2) |
                       (int'(!db) << 1) | 1);
          wr(2'd0, bad_cw);
          check("R11 en kept", AW'(en), 1);
          check("R11 dir frozen", AW'(dir), AW'(d));
          check("R11 dbuf frozen", AW'(dbuf), AW'(db));
          check("R11 ct frozen", AW'(ct), AW'(c_now));
          wr(2'd0, '0);
          check("R11 disable", AW'(en), 0);
          check("R11 dir after disable", AW'(dir), AW'(d));
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule